// File: doc/BRIEF.md
# Register-Pointer Serial Bus Slave

This block is the slave side of a two-wire I2C link. It gives an external host access to a small register file that sits next to it. A fast system clock samples both bus lines through synchronizers. From those samples the block finds START, repeated START and STOP conditions. It answers only its own fixed 7-bit device address and acknowledges by pulling the data line low during the ninth clock. The slave never holds the clock line, so SCL is an input only.

After a write address, the first byte is a command byte. Its low bits set an internal register pointer. Every further byte in the same transfer is stored at the pointer, and the pointer then steps forward. A read is done as a combined transfer. The host writes the pointer, issues a repeated START, then sends the address with the read bit set. The slave then returns the register at the pointer, MSB first. It moves on to the next register each time the host acknowledges a byte. A host not-acknowledge ends the read. The register file itself lives outside the block and is reached through a one-cycle write strobe and a combinational read port.

Top module: `regptr_i2c_slave`

## Requirements
- R1: The slave acknowledges (data line driven low through the ninth clock) only an address byte whose upper seven bits equal 7'h64; bit 0 of that byte is the direction, 0 = write, 1 = read. For any other address it gives no acknowledge, produces no register write and drives nothing until the next START or STOP.
- R2: In a write transfer, the first byte after the address is acknowledged and sets the pointer to that byte modulo 16 (the upper nibble is ignored). It produces no register write.
- R3: Each later byte of a write transfer is acknowledged and written to the register at the pointer. The pointer then steps by one modulo 16, so index 15 is followed by index 0.
- R4: A data byte aimed at a read-only index (by default only index 0) is acknowledged, but no write strobe is issued for it.
- R5: A repeated START restarts address matching exactly like a START. After write-address, command byte, repeated START and read-address, the slave returns the register at the pointer, MSB first.
- R6: When the host acknowledges a returned byte, the pointer steps by one modulo 16 and the next register is returned.
- R7: After the host not-acknowledges a returned byte, the slave releases the data line before the next rising clock. After a STOP it drives nothing.
- R8: The slave changes its data line drive only while SCL is low.
- R9: Out of reset the data line is released and no write strobe is active.
- R10: Each written data byte gives exactly one single-cycle write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaDriveLow | output | 1 | 1 pulls the data line low (open-drain enable) |
| regWrEn | output | 1 | One-cycle write strobe to the register file |
| regWrAddr | output | 4 | Register index being written |
| regWrData | output | 8 | Byte being written |
| regRdAddr | output | 4 | Register index currently selected for reading |
| regRdData | input | 8 | Contents of the register at regRdAddr |

## Verification
A wrong pointer shows up within one byte. It puts a write strobe at the wrong index, or the host reads back a byte that does not match the register at the expected index. A wrong protocol state shows up at the next ninth clock as a missing or extra acknowledge. It can also show as a data line that the slave is still holding when the host tries to make a STOP or repeated START. The bench sweeps all 128 addresses, every starting pointer for both writes and reads (this covers the wrap and the read-only index), and watches the drive-change timing on every bus cycle.

// File: rtl/regptr_i2c_pkg.sv
package regptr_i2c_pkg;

  localparam int BYTE_W = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadTx;
    logic clrBits;
    logic ptrLoad;
    logic ptrInc;
    logic regWrite;
  } dpCmd_t;

  // bus events and datapath flags seen by control
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
    logic sclLvl;
    logic sdaBit;
    logic byteDone;
    logic addrMatch;
    logic rwBit;
    logic txMsb;
    logic rdMsb;
  } busEv_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } slvState_t;

endpackage

// File: rtl/regptr_i2c_sync.sv
module regptr_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipeQ;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rstN) pipeQ <= '1;
        else       pipeQ <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rstN) pipeQ <= '1;
        else       pipeQ <= {pipeQ[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipeQ[STAGES-1];
endmodule

// File: rtl/regptr_i2c_dp.sv
module regptr_i2c_dp
  import regptr_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h64,
  parameter int         REG_COUNT   = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [REG_COUNT-1:0] RO_MASK = 1,
  localparam int ADDR_W = $clog2(REG_COUNT),
  localparam int CNT_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCmd_t            cmd,
  output busEv_t            ev,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdAddr,
  input  logic [BYTE_W-1:0] regRdData
);
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic [BYTE_W-1:0] shiftQ;
  logic [CNT_W-1:0]  bitCntQ;
  logic [ADDR_W-1:0] ptrQ;
  logic              wrEnQ;
  logic [ADDR_W-1:0] wrAddrQ;
  logic [BYTE_W-1:0] wrDataQ;

  regptr_i2c_sync #(.STAGES(SYNC_STAGES)) u_sclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS));
  regptr_i2c_sync #(.STAGES(SYNC_STAGES)) u_sdaSync (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  // shift register and bit counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ  <= '0;
      bitCntQ <= '0;
    end else begin
      if (cmd.loadTx)       shiftQ <= regRdData;
      else if (cmd.shiftIn) shiftQ <= {shiftQ[BYTE_W-2:0], sdaS};
      if (cmd.clrBits)      bitCntQ <= '0;
      else if (cmd.shiftIn) bitCntQ <= bitCntQ + 1'b1;
    end
  end

  // register pointer, wraps by width
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (cmd.ptrLoad) begin
      ptrQ <= shiftQ[ADDR_W-1:0];
    end else if (cmd.ptrInc) begin
      ptrQ <= ptrQ + 1'b1;
    end
  end

  // registered write port; read-only entries never strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEnQ   <= 1'b0;
      wrAddrQ <= '0;
      wrDataQ <= '0;
    end else begin
      wrEnQ <= cmd.regWrite && !RO_MASK[ptrQ];
      if (cmd.regWrite) begin
        wrAddrQ <= ptrQ;
        wrDataQ <= shiftQ;
      end
    end
  end

  always_comb begin
    ev.start     = sclS && sclPrev && sdaPrev && !sdaS;
    ev.stop      = sclS && sclPrev && !sdaPrev && sdaS;
    ev.sclRise   = sclS && !sclPrev;
    ev.sclFall   = !sclS && sclPrev;
    ev.sclLvl    = sclS;
    ev.sdaBit    = sdaS;
    ev.byteDone  = (bitCntQ == CNT_W'(BYTE_W));
    ev.addrMatch = (shiftQ[BYTE_W-1:1] == DEV_ADDR);
    ev.rwBit     = shiftQ[0];
    ev.txMsb     = shiftQ[BYTE_W-1];
    ev.rdMsb     = regRdData[BYTE_W-1];
  end

  assign regWrEn   = wrEnQ;
  assign regWrAddr = wrAddrQ;
  assign regWrData = wrDataQ;
  assign regRdAddr = ptrQ;

  // R10: a write strobe lasts one cycle
  p_wr_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);
  // R1: the bit counter never passes a full byte
  p_bitcnt_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    bitCntQ <= CNT_W'(BYTE_W));
  // R3: stepping from the last index lands on index 0
  p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.ptrInc && !cmd.ptrLoad && ptrQ == ADDR_W'(REG_COUNT-1)) |=> (regRdAddr == '0));
  // R4: no strobe toward a read-only index
  p_ro_silent_r4: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !RO_MASK[regWrAddr]);
endmodule

// File: rtl/regptr_i2c_ctrl.sv
module regptr_i2c_ctrl
  import regptr_i2c_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  busEv_t ev,
  output dpCmd_t cmd,
  output logic   sdaDriveLow
);
  slvState_t stQ, stNext;
  logic oeQ, oeNext, rwQ, rwNext, ackQ, ackNext;

  always_comb begin
    cmd     = '0;
    stNext  = stQ;
    oeNext  = oeQ;
    rwNext  = rwQ;
    ackNext = ackQ;
    if (ev.stop) begin
      stNext      = ST_IDLE;
      oeNext      = 1'b0;
      cmd.clrBits = 1'b1;
    end else if (ev.start) begin
      stNext      = ST_ADDR;
      oeNext      = 1'b0;
      cmd.clrBits = 1'b1;
    end else begin
      case (stQ)
        ST_ADDR: begin
          if (ev.sclRise) cmd.shiftIn = 1'b1;
          else if (ev.sclFall && ev.byteDone) begin
            if (ev.addrMatch) begin
              oeNext = 1'b1;
              rwNext = ev.rwBit;
              stNext = ST_ADDR_ACK;
            end else begin
              stNext = ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (ev.sclFall) begin
            cmd.clrBits = 1'b1;
            if (rwQ) begin
              cmd.loadTx = 1'b1;
              oeNext     = !ev.rdMsb;
              stNext     = ST_RDATA;
            end else begin
              oeNext = 1'b0;
              stNext = ST_CMD;
            end
          end
        end
        ST_CMD: begin
          if (ev.sclRise) cmd.shiftIn = 1'b1;
          else if (ev.sclFall && ev.byteDone) begin
            cmd.ptrLoad = 1'b1;
            oeNext      = 1'b1;
            stNext      = ST_CMD_ACK;
          end
        end
        ST_CMD_ACK, ST_WDATA_ACK: begin
          if (ev.sclFall) begin
            cmd.clrBits = 1'b1;
            oeNext      = 1'b0;
            stNext      = ST_WDATA;
          end
        end
        ST_WDATA: begin
          if (ev.sclRise) cmd.shiftIn = 1'b1;
          else if (ev.sclFall && ev.byteDone) begin
            cmd.regWrite = 1'b1;
            cmd.ptrInc   = 1'b1;
            oeNext       = 1'b1;
            stNext       = ST_WDATA_ACK;
          end
        end
        ST_RDATA: begin
          if (ev.sclRise) cmd.shiftIn = 1'b1;
          else if (ev.sclFall) begin
            if (ev.byteDone) begin
              oeNext = 1'b0;
              stNext = ST_RACK;
            end else begin
              oeNext = !ev.txMsb;
            end
          end
        end
        ST_RACK: begin
          if (ev.sclRise) begin
            ackNext    = !ev.sdaBit;
            cmd.ptrInc = !ev.sdaBit;
          end else if (ev.sclFall) begin
            if (ackQ) begin
              cmd.clrBits = 1'b1;
              cmd.loadTx  = 1'b1;
              oeNext      = !ev.rdMsb;
              stNext      = ST_RDATA;
            end else begin
              oeNext = 1'b0;
              stNext = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ  <= ST_IDLE;
      oeQ  <= 1'b0;
      rwQ  <= 1'b0;
      ackQ <= 1'b0;
    end else begin
      stQ  <= stNext;
      oeQ  <= oeNext;
      rwQ  <= rwNext;
      ackQ <= ackNext;
    end
  end

  assign sdaDriveLow = oeQ;

  // R8: the slave starts pulling low only while SCL is low
  p_drive_scl_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oeQ) |-> !ev.sclLvl);
  // R1: a mismatched address never gets an acknowledge
  p_ack_needs_match_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_ADDR && !ev.stop && !ev.start && ev.sclFall && ev.byteDone && !ev.addrMatch)
      |=> !sdaDriveLow);
  // R7: a STOP leaves the data line released
  p_stop_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    ev.stop |=> !sdaDriveLow);
  // R9: idle or ignoring states never drive
  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_IDLE || stQ == ST_IGNORE) |-> !sdaDriveLow);
endmodule

// File: rtl/regptr_i2c_slave.sv
module regptr_i2c_slave
  import regptr_i2c_pkg::*;
#(
  parameter logic [6:0]           DEV_ADDR    = 7'h64,
  parameter int                   REG_COUNT   = 16,
  parameter int                   SYNC_STAGES = 2,
  parameter logic [REG_COUNT-1:0] RO_MASK     = 1,
  localparam int ADDR_W = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [7:0]        regWrData,
  output logic [ADDR_W-1:0] regRdAddr,
  input  logic [7:0]        regRdData
);
  dpCmd_t cmd;
  busEv_t ev;

  regptr_i2c_dp #(
    .DEV_ADDR(DEV_ADDR), .REG_COUNT(REG_COUNT),
    .SYNC_STAGES(SYNC_STAGES), .RO_MASK(RO_MASK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .cmd(cmd), .ev(ev),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData)
  );

  regptr_i2c_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .cmd(cmd), .sdaDriveLow(sdaDriveLow)
  );
endmodule

// File: tb/regptr_i2c_slave_tb.sv
module regptr_i2c_slave_tb;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic sdaBus;
  logic sdaDriveLow, regWrEn;
  logic [3:0] regWrAddr, regRdAddr;
  logic [7:0] regWrData, regRdData;
  logic [7:0] regs [16];
  int nChecks = 0, nFails = 0, nWrites = 0, nEarly = 0;
  logic drvPrev = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign sdaBus = mSda && !sdaDriveLow;

  regptr_i2c_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData)
  );

  // bench-owned register file
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) regs[i] <= 8'(i * 37 + 5) ^ 8'hC3;
    end else if (regWrEn) begin
      regs[regWrAddr] <= regWrData;
      nWrites <= nWrites + 1;
    end
  end
  always_comb regRdData = regs[regRdAddr];

  // R8 monitor: drive must not change while SCL is high
  always @(posedge clk) begin
    if (rstN && scl && (sdaDriveLow != drvPrev)) nEarly <= nEarly + 1;
    drvPrev <= sdaDriveLow;
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clkBit(output logic s);
    waitClk(Q); scl = 1'b1;
    waitClk(Q); s = sdaBus;
    waitClk(Q); scl = 1'b0;
    waitClk(2);
  endtask

  task automatic busStart();
    mSda = 1'b1; scl = 1'b1; waitClk(Q);
    mSda = 1'b0; waitClk(Q);
    scl = 1'b0; waitClk(2);
  endtask

  task automatic busRestart();
    mSda = 1'b1; waitClk(Q);
    scl = 1'b1; waitClk(Q);
    mSda = 1'b0; waitClk(Q);
    scl = 1'b0; waitClk(2);
  endtask

  task automatic busStop();
    mSda = 1'b0; waitClk(Q);
    scl = 1'b1; waitClk(Q);
    mSda = 1'b1; waitClk(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i];
      clkBit(s);
    end
    mSda = 1'b1;
    clkBit(s);
    acked = (s == 1'b0);
  endtask

  task automatic readByte(input bit mAck, output logic [7:0] b);
    logic s;
    mSda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      clkBit(s);
      b = {b[6:0], s};
    end
    mSda = !mAck;
    clkBit(s);
    mSda = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    bit ack, ack2;
    logic [7:0] got;
    logic [7:0] snap [16];
    int w0;
    waitClk(5);
    // R9: reset state
    check(sdaDriveLow == 1'b0, "R9 drive at reset", int'(sdaDriveLow), 0);
    check(regWrEn == 1'b0, "R9 strobe at reset", int'(regWrEn), 0);
    rstN = 1'b1;
    waitClk(5);
    check(sdaDriveLow == 1'b0, "R9 drive after reset", int'(sdaDriveLow), 0);

    // R1: sweep of every address with write direction
    for (int a = 0; a < 128; a++) begin
      busStart();
      sendByte({7'(a), 1'b0}, ack);
      check(ack == (a == 'h64), "R1 address ack", int'(ack), int'(a == 'h64));
      busStop();
    end

    // R1: mismatched address followed by bytes: no ack, no write
    w0 = nWrites;
    busStart();
    sendByte(8'hCA, ack);
    sendByte(8'h03, ack2);
    check(!ack2, "R1 byte after mismatch ack", int'(ack2), 0);
    sendByte(8'hAA, ack2);
    check(!ack2, "R1 data after mismatch ack", int'(ack2), 0);
    check(sdaDriveLow == 1'b0, "R1 ignoring drive", int'(sdaDriveLow), 0);
    busStop();
    check(nWrites == w0, "R1 writes after mismatch", nWrites - w0, 0);

    // R2: command byte alone acknowledged, produces no write
    w0 = nWrites;
    busStart();
    sendByte(8'hC8, ack);
    sendByte(8'hF7, ack2);
    check(ack2, "R2 command ack", int'(ack2), 1);
    busStop();
    check(nWrites == w0, "R2 command no write", nWrites - w0, 0);

    // R3/R4/R10: three-byte write from every start index
    for (int p = 0; p < 16; p++) begin
      int expW;
      for (int k = 0; k < 16; k++) snap[k] = regs[k];
      w0 = nWrites;
      expW = 0;
      busStart();
      sendByte(8'hC8, ack);
      // R2: upper nibble of the command byte is ignored
      sendByte(8'(p * 17), ack);
      for (int i = 0; i < 3; i++) begin
        sendByte(8'(p * 29 + i * 71 + 3), ack);
        check(ack, "R3 data ack", int'(ack), 1);
        if (((p + i) % 16) != 0) expW++;
      end
      busStop();
      for (int i = 0; i < 3; i++) begin
        int idx;
        idx = (p + i) % 16;
        if (idx == 0)
          check(regs[0] == snap[0], "R4 read-only kept", int'(regs[0]), int'(snap[0]));
        else
          check(regs[idx] == 8'(p * 29 + i * 71 + 3), "R3 written value",
                int'(regs[idx]), (p * 29 + i * 71 + 3) & 255);
      end
      check(nWrites - w0 == expW, "R10 strobe count", nWrites - w0, expW);
    end

    // R5/R6/R7: combined read of three bytes from every start index
    for (int p = 0; p < 16; p++) begin
      busStart();
      sendByte(8'hC8, ack);
      sendByte(8'(p), ack);
      busRestart();
      sendByte(8'hC9, ack);
      check(ack, "R5 read address ack", int'(ack), 1);
      for (int i = 0; i < 3; i++) begin
        int idx;
        idx = (p + i) % 16;
        readByte(i < 2, got);
        check(got == regs[idx], i == 0 ? "R5 first read byte" : "R6 next read byte",
              int'(got), int'(regs[idx]));
      end
      check(sdaDriveLow == 1'b0, "R7 released after nack", int'(sdaDriveLow), 0);
      busStop();
      waitClk(Q);
      check(sdaDriveLow == 1'b0, "R7 released after stop", int'(sdaDriveLow), 0);
    end

    check(nEarly == 0, "R8 drive change while scl high", nEarly, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule